// File: doc/BRIEF.md
# PLL Loop-Bandwidth Calibration Sequencer

This block is the digital controller that tunes a transmit phase-locked loop in the quiet interval before a burst. A start request opens the loop and parks the VCO control voltage at a fixed midscale level. The sequencer then picks one of four coarse tank bands and trims a control-voltage DAC so that the VCO frequency lands on a target count. Last, it estimates the VCO gain and chooses a charge-pump current code in inverse proportion to that gain. Loop bandwidth depends on the product of VCO gain and pump current, so a calibrated code keeps the bandwidth close to its design value from part to part.

Frequency is read by counting synchronized VCO-derived tick pulses over a fixed window of reference cycles. Both searches are successive approximation, MSB first. A trial bit stays set when the measured count does not exceed the target. The gain estimate is the count difference between a low and a high DAC setting. A multi-cycle restoring divider turns that difference into a pump code. In the narrowband mode the pump code is halved and a doubled loop-filter capacitor is selected. When the sequence ends, the loop closes, all codes hold, and a one-cycle done pulse is issued.

Top module: `vcal_bw_sequencer`

## Requirements
- R1: Out of reset: band_o=0, dac_o=0, cp_code_o=0, cap_dbl_o=0, loop_open_o=0, busy_o=0, done_o=0.
- R2: A start_i seen while idle captures target_i and gsm_mode_i. From the next cycle busy_o and loop_open_o are 1, dac_o is the midscale code 2^(DAC_W-1), and band_o shows the first trial code 2 (binary 10).
- R3: A measurement counts the cycles with tick_i high over exactly WIN reference cycles. band_o and dac_o do not change during a counting window, and a count never exceeds WIN.
- R4: The band search tests band bit 1, then bit 0, with dac_o at midscale. It ends on the largest band whose count is at or below the target, or on 0 if none qualifies.
- R5: The DAC search then runs MSB first with the band held. It ends on the largest DAC code whose count is at or below the target, or on 0 if none qualifies.
- R6: The gain is measured at DAC codes DAC_MAX/4 and (3*DAC_MAX)/4, rounded down, where DAC_MAX=2^DAC_W-1. The difference is the high count minus the low count, taken as 0 when not positive.
- R7: The calibrated code is K_NUM divided by the difference, rounded down. It is clamped to CP_MAX=2^CP_W-1 when the difference is 0 or the quotient exceeds CP_MAX.
- R8: With gsm_mode_i=1 captured, cp_code_o is the calibrated code shifted right by one and cap_dbl_o=1. With 0, cp_code_o is the calibrated code and cap_dbl_o=0.
- R9: At the end, done_o pulses for exactly one cycle, busy_o and loop_open_o fall, and dac_o returns to the trimmed code. cp_code_o and cap_dbl_o change only in the done cycle.
- R10: start_i, target_i and gsm_mode_i have no effect while busy_o is high.
- R11: From start to done the sequence takes fewer than CYC_BUDGET cycles (2600, which is 200 us at a 13 MHz reference).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration request |
| target_i | input | $clog2(WIN+1) | Target channel count |
| gsm_mode_i | input | 1 | 1 = narrowband mode, 0 = wideband mode |
| tick_i | input | 1 | Synchronized VCO-derived tick, at most one per cycle |
| band_o | output | 2 | Coarse tank band code |
| dac_o | output | DAC_W | Control-voltage DAC code |
| loop_open_o | output | 1 | 1 = loop opened and control voltage driven by the DAC |
| cp_code_o | output | CP_W | Charge-pump current code |
| cap_dbl_o | output | 1 | Doubled loop-filter pole capacitor select |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that the following hold:
- codes stay frozen inside a counting window and counts stay bounded;
- each SAR trial bit is kept or dropped as its decision says;
- the band stays put through the later phases;
- every divider result is the exact rounded-down quotient;
- the captured request cannot change mid-run;
- done is a single pulse with the outputs held;
- the cycle budget is met.

Only the bench scenarios can show the results themselves. It drives a linear VCO count model over many slopes, targets and both modes, and compares the final band, DAC and pump codes with the largest qualifying codes and the clamped quotient it computes itself. This includes the zero-gain and out-of-range targets and a start request issued in mid-run.

// File: rtl/vcal_pkg.sv
package vcal_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_BAND,
    PH_DAC,
    PH_GLO,
    PH_GHI,
    PH_DIV
  } phase_e;

  // SAR decision: a trial bit survives when the count does not exceed the target
  function automatic logic f_keep(input logic [31:0] cnt, input logic [31:0] tgt);
    return cnt <= tgt;
  endfunction

  // Gain estimate from two counts, floored at zero
  function automatic logic [31:0] f_gain_diff(input logic [31:0] hi, input logic [31:0] lo);
    return (hi > lo) ? (hi - lo) : 32'd0;
  endfunction

  // Clamp the quotient, then apply the narrowband halving
  function automatic logic [31:0] f_cp_code(input logic [31:0] quot, input logic [31:0] diff,
                                            input logic [31:0] cp_max, input logic gsm);
    logic [31:0] cal;
    cal = (diff == 32'd0 || quot > cp_max) ? cp_max : quot;
    return gsm ? (cal >> 1) : cal;
  endfunction

endpackage

// File: rtl/vcal_freq_meter.sv
module vcal_freq_meter #(
  parameter int WIN   = 200,
  parameter int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             active_o
);
  localparam int LW = $clog2(WIN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [LW-1:0]    left_q;
  logic             active_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        cnt_q    <= '0;
        left_q   <= LW'(WIN);
        active_q <= 1'b1;
      end else if (active_q) begin
        cnt_q  <= cnt_q + CNT_W'(tick_i);
        left_q <= left_q - LW'(1);
        if (left_q == LW'(1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign done_o   = done_q;
  assign active_o = active_q;

  // R3: a finished count never exceeds the window length
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q <= CNT_W'(WIN)));

  // R3: inside a window the count grows by zero or one per cycle
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !go_i) |=> (cnt_q >= $past(cnt_q)) && (cnt_q <= $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/vcal_sar.sv
module vcal_sar #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         keep_i,
  output logic [W-1:0] code_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP_BIT = W'(1) << (W - 1);

  logic [W-1:0] code_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] code_nxt;

  always_comb begin
    code_nxt = code_q;
    if (!keep_i) code_nxt = code_nxt & ~mask_q;
    code_nxt = code_nxt | (mask_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      code_q <= TOP_BIT;
      mask_q <= TOP_BIT;
    end else if (step_i) begin
      code_q <= code_nxt;
      mask_q <= mask_q >> 1;
    end
  end

  assign code_o = code_q;
  assign last_o = mask_q[0];

  // R4/R5: only one bit is ever under trial
  a_r4_trial_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));

  // R4/R5: a kept trial bit remains set after the step
  a_r4_keep_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && keep_i) |=> ((code_q & $past(mask_q)) == $past(mask_q)));

  // R4/R5: a rejected trial bit is cleared after the step
  a_r4_drop_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && !keep_i) |=> ((code_q & $past(mask_q)) == '0));

endmodule

// File: rtl/vcal_divider.sv
module vcal_divider #(
  parameter int NUM_W = 10,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             done_o
);
  localparam int LW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q;
  logic [NUM_W-1:0] num_sh;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [LW-1:0]    left_q;
  logic             run_q;
  logic             done_q;

  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, num_sh[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      num_sh <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        num_q  <= num_i;
        num_sh <= num_i;
        den_q  <= den_i;
        rem_q  <= '0;
        quo_q  <= '0;
        left_q <= LW'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], fits};
        num_sh <= num_sh << 1;
        left_q <= left_q - LW'(1);
        if (left_q == LW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;

  // R7: the finished quotient is the exact rounded-down result
  a_r7_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && den_q != '0) |->
      ((64'(quo_q) * 64'(den_q) <= 64'(num_q)) &&
       (64'(num_q) < (64'(quo_q) + 64'd1) * 64'(den_q))));

endmodule

// File: rtl/vcal_bw_sequencer.sv
module vcal_bw_sequencer
  import vcal_pkg::*;
#(
  parameter int DAC_W      = 6,
  parameter int CP_W       = 6,
  parameter int WIN        = 200,
  parameter int K_NUM      = 512,
  parameter int CYC_BUDGET = 2600
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [$clog2(WIN+1)-1:0] target_i,
  input  logic                     gsm_mode_i,
  input  logic                     tick_i,
  output logic [1:0]               band_o,
  output logic [DAC_W-1:0]         dac_o,
  output logic                     loop_open_o,
  output logic [CP_W-1:0]          cp_code_o,
  output logic                     cap_dbl_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int CNT_W    = $clog2(WIN + 1);
  localparam int BAND_W   = 2;
  localparam int DAC_MAX  = (1 << DAC_W) - 1;
  localparam int DAC_REF  = 1 << (DAC_W - 1);
  localparam int GAIN_LO  = DAC_MAX / 4;
  localparam int GAIN_HI  = (3 * DAC_MAX) / 4;
  localparam int CP_MAX   = (1 << CP_W) - 1;
  localparam int K_W      = $clog2(K_NUM + 1);

  phase_e           st_q;
  logic [CNT_W-1:0] tgt_q;
  logic             gsm_q;
  logic [CNT_W-1:0] lo_cnt_q;
  logic [CNT_W-1:0] diff_q;
  logic             go_q;
  logic             div_go_q;
  logic [CP_W-1:0]  cp_q;
  logic             cap_q;
  logic             done_q;
  logic [31:0]      busy_cyc_q;

  // Named internal events
  logic             start_accept;
  logic             meas_done;
  logic             meas_active;
  logic [CNT_W-1:0] meas_cnt;
  logic             trial_keep;
  logic             band_step;
  logic             dac_step;
  logic             dac_clr;
  logic             band_last;
  logic             dac_last;
  logic [BAND_W-1:0] band_code;
  logic [DAC_W-1:0] dac_code;
  logic [K_W-1:0]   div_quo;
  logic             div_done;

  assign start_accept = (st_q == PH_IDLE) && start_i;
  assign trial_keep   = f_keep(32'(meas_cnt), 32'(tgt_q));
  assign band_step    = meas_done && (st_q == PH_BAND);
  assign dac_step     = meas_done && (st_q == PH_DAC);
  assign dac_clr      = band_step && band_last;

  vcal_freq_meter #(.WIN(WIN), .CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (go_q),
    .tick_i   (tick_i),
    .cnt_o    (meas_cnt),
    .done_o   (meas_done),
    .active_o (meas_active)
  );

  vcal_sar #(.W(BAND_W)) u_band_sar (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_accept),
    .step_i (band_step),
    .keep_i (trial_keep),
    .code_o (band_code),
    .last_o (band_last)
  );

  vcal_sar #(.W(DAC_W)) u_dac_sar (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (dac_clr),
    .step_i (dac_step),
    .keep_i (trial_keep),
    .code_o (dac_code),
    .last_o (dac_last)
  );

  vcal_divider #(.NUM_W(K_W), .DEN_W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (div_go_q),
    .num_i  (K_W'(K_NUM)),
    .den_i  (diff_q),
    .quo_o  (div_quo),
    .done_o (div_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PH_IDLE;
      tgt_q    <= '0;
      gsm_q    <= 1'b0;
      lo_cnt_q <= '0;
      diff_q   <= '0;
      go_q     <= 1'b0;
      div_go_q <= 1'b0;
      cp_q     <= '0;
      cap_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      go_q     <= 1'b0;
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (st_q)
        PH_IDLE: begin
          if (start_i) begin
            st_q  <= PH_BAND;
            tgt_q <= target_i;
            gsm_q <= gsm_mode_i;
            go_q  <= 1'b1;
          end
        end
        PH_BAND: begin
          if (meas_done) begin
            go_q <= 1'b1;
            if (band_last) st_q <= PH_DAC;
          end
        end
        PH_DAC: begin
          if (meas_done) begin
            go_q <= 1'b1;
            if (dac_last) st_q <= PH_GLO;
          end
        end
        PH_GLO: begin
          if (meas_done) begin
            lo_cnt_q <= meas_cnt;
            go_q     <= 1'b1;
            st_q     <= PH_GHI;
          end
        end
        PH_GHI: begin
          if (meas_done) begin
            diff_q   <= CNT_W'(f_gain_diff(32'(meas_cnt), 32'(lo_cnt_q)));
            div_go_q <= 1'b1;
            st_q     <= PH_DIV;
          end
        end
        PH_DIV: begin
          if (div_done) begin
            cp_q   <= CP_W'(f_cp_code(32'(div_quo), 32'(diff_q), 32'(CP_MAX), gsm_q));
            cap_q  <= gsm_q;
            done_q <= 1'b1;
            st_q   <= PH_IDLE;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  // Cycle budget counter, used by the budget assertion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cyc_q <= '0;
    else if (st_q == PH_IDLE)  busy_cyc_q <= '0;
    else                       busy_cyc_q <= busy_cyc_q + 32'd1;
  end

  always_comb begin
    unique case (st_q)
      PH_BAND: dac_o = DAC_W'(DAC_REF);
      PH_GLO:  dac_o = DAC_W'(GAIN_LO);
      PH_GHI:  dac_o = DAC_W'(GAIN_HI);
      default: dac_o = dac_code;
    endcase
  end

  assign band_o      = band_code;
  assign loop_open_o = (st_q != PH_IDLE);
  assign busy_o      = (st_q != PH_IDLE);
  assign cp_code_o   = cp_q;
  assign cap_dbl_o   = cap_q;
  assign done_o      = done_q;

  // R2: an accepted start opens the loop at the midscale level
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE && start_i) |=> (busy_o && loop_open_o && dac_o == DAC_W'(DAC_REF)));

  // R3: VCO codes are frozen across a counting window
  a_r3_codes_still: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_active && $past(meas_active)) |-> ($stable(band_o) && $stable(dac_o)));

  // R5: the band found first is held through every later phase
  a_r5_band_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PH_IDLE && st_q != PH_BAND && $past(st_q) != PH_IDLE && $past(st_q) != PH_BAND)
      |-> $stable(band_o));

  // R8: narrowband results never exceed half the code range
  a_r8_gsm_half: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && gsm_q) |-> (cp_code_o <= CP_W'(CP_MAX / 2) && cap_dbl_o));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: results move only in the completion cycle
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(cp_code_o) && $stable(cap_dbl_o)));

  // R9: at completion the loop is closed and the block is free
  a_r9_closed: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!loop_open_o && !busy_o));

  // R10: the captured request cannot change during a run
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(tgt_q) && $stable(gsm_q)));

  // R11: a run stays inside the settling allowance
  a_r11_budget: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_cyc_q < 32'(CYC_BUDGET)));

endmodule

// File: tb/tb_vcal_bw_sequencer.sv
module tb_vcal_bw_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 200;
  localparam int DAC_W      = 6;
  localparam int CP_W       = 6;
  localparam int K_NUM      = 512;
  localparam int BUDGET     = 2600;
  localparam int CNT_W      = $clog2(WIN + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] target = '0;
  logic             gsm = 1'b0;
  logic             tick = 1'b0;
  logic [1:0]       band;
  logic [DAC_W-1:0] dac;
  logic             loop_open;
  logic [CP_W-1:0]  cp;
  logic             cap;
  logic             busy;
  logic             done;

  int n_checks = 0;
  int n_fail   = 0;
  int slope    = 0;
  int acc      = 0;
  int tcyc     = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vcal_bw_sequencer #(.DAC_W(DAC_W), .CP_W(CP_W), .WIN(WIN), .K_NUM(K_NUM),
                      .CYC_BUDGET(BUDGET)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
    .gsm_mode_i(gsm), .tick_i(tick), .band_o(band), .dac_o(dac),
    .loop_open_o(loop_open), .cp_code_o(cp), .cap_dbl_o(cap),
    .busy_o(busy), .done_o(done)
  );

  // Linear VCO model: count per window = 20 + 36*band + floor(dac*slope/4)
  function automatic int fmodel(int b, int d, int s);
    return 20 + 36 * b + (d * s) / 4;
  endfunction

  // Tick generator: exactly fmodel ticks in any WIN cycles with constant codes
  always @(negedge clk) begin
    acc = acc + fmodel(int'(band), int'(dac), slope);
    if (acc >= WIN) begin
      tick = 1'b1;
      acc  = acc - WIN;
    end else begin
      tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    tcyc++;
    if (tcyc > 195000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", tcyc, 195000);
      summary();
      $finish;
    end
  end

  task automatic run_cal(input int t, input int s, input bit g, input bit poke);
    int eb, ed, diff, cal, ecp, cyc;
    bit seen_lo, seen_hi;
    // expected values from the requirements
    eb = 0;
    for (int b = 3; b >= 0; b--) if (eb == 0 && fmodel(b, 32, s) <= t) eb = b;
    ed = 0;
    for (int d = 63; d >= 0; d--) if (ed == 0 && fmodel(eb, d, s) <= t) ed = d;
    diff = fmodel(eb, (63 * 3) / 4, s) - fmodel(eb, 63 / 4, s);
    if (diff <= 0) cal = 63;
    else cal = (K_NUM / diff > 63) ? 63 : K_NUM / diff;
    ecp = g ? cal / 2 : cal;

    slope = s;
    @(negedge clk);
    target = CNT_W'(t);
    gsm    = g;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    // R2: loop opened at midscale, first band trial 2
    chk("R2 busy", int'(busy), 1);
    chk("R2 loop_open", int'(loop_open), 1);
    chk("R2 dac midscale", int'(dac), 32);
    chk("R4 first band trial", int'(band), 2);
    cyc = 1; seen_lo = 0; seen_hi = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (dac == 6'd15 && busy) seen_lo = 1;
      if (dac == 6'd47 && busy) seen_hi = 1;
      if (poke && cyc == 300) begin
        start  = 1'b1;            // R10: request while busy
        target = ~CNT_W'(t);
        gsm    = ~g;
      end
      if (poke && cyc == 301) start = 1'b0;
    end
    chk("R9 done seen", int'(done), 1);
    chk("R11 cycles within budget", int'(cyc < BUDGET), 1);
    chk("R4 band result", int'(band), eb);
    chk("R5 dac result (R3 counts)", int'(dac), ed);
    chk("R6 gain points visited", int'(seen_lo && seen_hi), 1);
    chk("R7 cp code", int'(cp), ecp);
    chk("R8 cap select", int'(cap), int'(g));
    chk("R9 loop closed", int'(loop_open), 0);
    chk("R9 busy low", int'(busy), 0);
    if (poke) chk("R10 start ignored, result kept", int'(cp), ecp);
    @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
    chk("R9 cp held", int'(cp), ecp);
    chk("R10 no restart", int'(busy), 0);
    target = '0;
    gsm    = 1'b0;
  endtask

  initial begin
    int tg[5] = '{5, 58, 95, 130, 190};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 band", int'(band), 0);
    chk("R1 dac", int'(dac), 0);
    chk("R1 cp", int'(cp), 0);
    chk("R1 cap", int'(cap), 0);
    chk("R1 loop_open", int'(loop_open), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int s = 0; s <= 4; s++)
      for (int i = 0; i < 5; i++)
        for (int g = 0; g < 2; g++)
          run_cal(tg[i], s, g[0], 1'b0);
    run_cal(95, 2, 1'b0, 1'b1);
    run_cal(130, 3, 1'b1, 1'b1);
    finished = 1;
    summary();
    $finish;
  end

endmodule